// File: doc/BRIEF.md
# UART Hardware Flow-Control Controller

This block adds out-of-band RTS/CTS handshaking to a plain asynchronous serial link. On the receive side it keeps a receiver-enable state and a buffer-full flag. When handshaking is selected, it drives RTS high whenever the receiver is off or the buffer is full, which asks the remote end to pause. A strobe from the buffer manager sets the buffer-full flag. Clearing the flag stands for a fresh buffer being allocated, and it lowers RTS again.

On the transmit side it contains a small character shifter with a one-entry holding register. A synchronized copy of CTS is checked only at the moment the shifter would leave idle. While CTS is high, a held character waits, and a character already on the line always runs to its stop bit. Every change of the synchronized CTS level sets a sticky flag, which can also raise an interrupt.

A break detector watches the receive line. It raises a sticky break flag when the line goes low for a full frame, and raises it again when the line returns high for at least two consecutive oversampling ticks. Baud rate comes from an external 16x tick strobe.

Top module: `uart_flow_ctl`

## Requirements
- R1: A mode value of 2 selects handshaking. With any other mode value, RTS stays low and CTS has no effect on when characters start.
- R2: In handshaking mode, RTS is high while the receiver is disabled.
- R3: In handshaking mode, a buffer-full strobe sets the buffer-full flag and drives RTS high, even while the receiver is enabled.
- R4: A buffer-clear strobe while the receiver is enabled returns RTS low. If set and clear arrive in the same cycle, set wins.
- R5: The receiver-enable and receiver-disable strobes take effect on the next clock. When both arrive in the same cycle, the receiver ends up disabled.
- R6: In handshaking mode, if synchronized CTS is high when the idle shifter would start a character, no start bit is sent. The written character stays held (tx_pending = 1) until CTS goes low.
- R7: A character that has started always completes, even if CTS rises during it. A frame is one low start bit, then 8 data bits LSB first, then one high stop bit, with each bit lasting 16 ticks.
- R8: Each level change of CTS after its two-flop synchronizer sets the sticky cts_chg flag. The reset-status strobe clears the flag. cts_irq follows cts_chg only while cts_irq_en is 1.
- R9: When the synchronized receive line is low for 160 consecutive ticks, the design detects a break and sets brk_stat.
- R10: After a break, the line being high for 2 consecutive ticks ends the break and sets brk_stat again. A single high tick does not end the break.
- R11: After reset: mode is normal, the receiver is disabled, rts = 0, txd = 1, tx_pending = 0, and cts_chg, cts_irq and brk_stat are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr | input | 1 | Write strobe for the mode field |
| mode_wdata | input | 4 | New mode value (2 = handshaking) |
| rx_en_stb | input | 1 | Enable receiver |
| rx_dis_stb | input | 1 | Disable receiver (wins over enable) |
| buf_full_stb | input | 1 | Buffer-full indication from the buffer manager |
| buf_full_clr | input | 1 | New buffer allocated, clears buffer-full |
| rst_stat_stb | input | 1 | Clears cts_chg and brk_stat |
| cts_irq_en | input | 1 | Interrupt enable for CTS changes |
| cts_in | input | 1 | Asynchronous CTS from the remote device |
| rxd | input | 1 | Asynchronous receive line |
| tick16 | input | 1 | 16x oversampling tick |
| tx_wr | input | 1 | Write a character into the holding register |
| tx_wdata | input | 8 | Character to send |
| rts | output | 1 | RTS toward the remote device |
| txd | output | 1 | Serial transmit line |
| tx_pending | output | 1 | Holding register occupied |
| cts_chg | output | 1 | Sticky CTS-change flag |
| cts_irq | output | 1 | CTS-change interrupt |
| brk_stat | output | 1 | Sticky break flag |

## Verification
The shifter is driven four ways: with CTS low in handshaking mode, with CTS high before a write, with CTS rising in the middle of a character while a second character waits, and with CTS high in normal mode. Together these separate a correct gate from one that is missing, one that ignores the mode, and one that cuts a running frame short. RTS is checked across the receiver-enable and buffer-full combinations, including simultaneous strobes, to expose a wrong priority. The break detector gets a full-frame low, then a one-tick high glitch, then a proper high. This distinguishes the two-tick end-of-break rule from a one-tick rule.

// File: rtl/fc_pkg.sv
package fc_pkg;
  localparam int MODE_W = 4;
  localparam logic [MODE_W-1:0] MODE_HANDSHAKE = 4'h2;
  typedef enum logic {TX_IDLE, TX_SHIFT} tx_state_t;
endpackage

// File: rtl/fc_cts_sync.sv
module fc_cts_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cts_in,
  input  logic clr,
  input  logic irq_en,
  output logic cts_s,
  output logic chg,
  output logic irq
);
  logic [STAGES-1:0] sr;
  logic cts_d;
  logic edge_seen;

  always_ff @(posedge clk) begin
    if (rst) sr <= '0;
    else     sr <= {sr[STAGES-2:0], cts_in};
  end

  assign cts_s     = sr[STAGES-1];
  assign edge_seen = cts_s ^ cts_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      cts_d <= 1'b0;
      chg   <= 1'b0;
      irq   <= 1'b0;
    end else begin
      cts_d <= cts_s;
      if (edge_seen)  chg <= 1'b1;
      else if (clr)   chg <= 1'b0;
      irq <= chg & irq_en;
    end
  end

  // R8: a change on the synchronized line leaves the flag set
  a_r8_edge_sets: assert property (@(posedge clk) disable iff (rst)
    (cts_s != cts_d) |=> chg);
  // R8: flag holds until cleared
  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    (chg && !clr) |=> chg);
endmodule

// File: rtl/fc_rx_ctrl.sv
module fc_rx_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic hs,
  input  logic en_stb,
  input  logic dis_stb,
  input  logic full_stb,
  input  logic full_clr,
  output logic rts
);
  logic rx_en;
  logic buf_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_en    <= 1'b0;
      buf_full <= 1'b0;
      rts      <= 1'b0;
    end else begin
      if (dis_stb)     rx_en <= 1'b0;
      else if (en_stb) rx_en <= 1'b1;
      if (full_stb)      buf_full <= 1'b1;
      else if (full_clr) buf_full <= 1'b0;
      rts <= hs & (~rx_en | buf_full);
    end
  end

  a_r1_rts_low_normal: assert property (@(posedge clk) disable iff (rst)
    !hs |=> !rts);
  a_r2_rts_rx_off: assert property (@(posedge clk) disable iff (rst)
    (hs && !rx_en) |=> rts);
  a_r3_rts_full: assert property (@(posedge clk) disable iff (rst)
    (hs && buf_full) |=> rts);
  a_r5_dis_priority: assert property (@(posedge clk) disable iff (rst)
    (en_stb && dis_stb) |=> !rx_en);
endmodule

// File: rtl/fc_tx.sv
module fc_tx
  import fc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              hs,
  input  logic              cts_s,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              txd,
  output logic              pending
);
  localparam int FRAME = DATA_W + 2;
  localparam int BC_W  = $clog2(FRAME);
  localparam int OS_W  = $clog2(OVS);

  tx_state_t         state;
  logic [DATA_W-1:0] hold;
  logic [FRAME-1:0]  shreg;
  logic [BC_W-1:0]   bit_cnt;
  logic [OS_W-1:0]   os_cnt;
  logic              blocked;
  logic              launch;

  assign blocked = hs & cts_s;
  assign launch  = tick && (state == TX_IDLE) && pending && !blocked;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= TX_IDLE;
      hold    <= '0;
      pending <= 1'b0;
      shreg   <= '1;
      bit_cnt <= '0;
      os_cnt  <= '0;
      txd     <= 1'b1;
    end else begin
      if (wr && !pending) begin
        hold    <= wdata;
        pending <= 1'b1;
      end
      if (launch) begin
        shreg   <= {1'b1, hold, 1'b0};
        pending <= 1'b0;
        state   <= TX_SHIFT;
        bit_cnt <= '0;
        os_cnt  <= '0;
        txd     <= 1'b0;
      end else if (tick && state == TX_SHIFT) begin
        if (os_cnt == OS_W'(OVS-1)) begin
          os_cnt <= '0;
          if (bit_cnt == BC_W'(FRAME-1)) begin
            state <= TX_IDLE;
            txd   <= 1'b1;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
            shreg   <= {1'b1, shreg[FRAME-1:1]};
            txd     <= shreg[1];
          end
        end else begin
          os_cnt <= os_cnt + 1'b1;
        end
      end
    end
  end

  a_r6_hold_when_blocked: assert property (@(posedge clk) disable iff (rst)
    (state == TX_IDLE && pending && blocked) |=> (state == TX_IDLE && pending));
  a_r7_no_abort: assert property (@(posedge clk) disable iff (rst)
    (state == TX_SHIFT && bit_cnt != BC_W'(FRAME-1)) |=> state == TX_SHIFT);
  a_r7_idle_high: assert property (@(posedge clk) disable iff (rst)
    (state == TX_IDLE && $past(state) == TX_IDLE) |-> txd);
endmodule

// File: rtl/fc_break_det.sv
module fc_break_det #(
  parameter int OVS         = 16,
  parameter int FRAME_BITS  = 10,
  parameter int END_SAMPLES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic rxd,
  input  logic clr,
  output logic brk_stat
);
  localparam int BRK_SAMPLES = OVS * FRAME_BITS;
  localparam int LO_W = $clog2(BRK_SAMPLES + 1);
  localparam int HI_W = $clog2(END_SAMPLES + 1);

  logic [1:0]      rx_sync;
  logic            rx_s;
  logic            in_brk;
  logic [LO_W-1:0] lo_cnt;
  logic [HI_W-1:0] hi_cnt;
  logic            set_ev;

  assign rx_s = rx_sync[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_sync <= 2'b11;
      in_brk  <= 1'b0;
      lo_cnt  <= '0;
      hi_cnt  <= '0;
      set_ev  <= 1'b0;
    end else begin
      rx_sync <= {rx_sync[0], rxd};
      set_ev  <= 1'b0;
      if (tick) begin
        if (!in_brk) begin
          if (!rx_s) begin
            if (lo_cnt == LO_W'(BRK_SAMPLES - 1)) begin
              in_brk <= 1'b1;
              set_ev <= 1'b1;
              lo_cnt <= '0;
            end else begin
              lo_cnt <= lo_cnt + 1'b1;
            end
          end else begin
            lo_cnt <= '0;
          end
          hi_cnt <= '0;
        end else begin
          if (rx_s) begin
            if (hi_cnt == HI_W'(END_SAMPLES - 1)) begin
              in_brk <= 1'b0;
              set_ev <= 1'b1;
              hi_cnt <= '0;
            end else begin
              hi_cnt <= hi_cnt + 1'b1;
            end
          end else begin
            hi_cnt <= '0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         brk_stat <= 1'b0;
    else if (set_ev) brk_stat <= 1'b1;
    else if (clr)    brk_stat <= 1'b0;
  end

  a_r10_low_keeps_break: assert property (@(posedge clk) disable iff (rst)
    (in_brk && tick && !rx_s) |=> in_brk);
  a_r9_set_flags: assert property (@(posedge clk) disable iff (rst)
    set_ev |=> brk_stat);
endmodule

// File: rtl/uart_flow_ctl.sv
module uart_flow_ctl
  import fc_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2,
  parameter int END_SAMPLES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_wr,
  input  logic [MODE_W-1:0] mode_wdata,
  input  logic              rx_en_stb,
  input  logic              rx_dis_stb,
  input  logic              buf_full_stb,
  input  logic              buf_full_clr,
  input  logic              rst_stat_stb,
  input  logic              cts_irq_en,
  input  logic              cts_in,
  input  logic              rxd,
  input  logic              tick16,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_wdata,
  output logic              rts,
  output logic              txd,
  output logic              tx_pending,
  output logic              cts_chg,
  output logic              cts_irq,
  output logic              brk_stat
);
  localparam int FRAME_BITS = DATA_W + 2;

  logic [MODE_W-1:0] mode_q;
  logic              hs;
  logic              cts_s;

  always_ff @(posedge clk) begin
    if (rst)          mode_q <= '0;
    else if (mode_wr) mode_q <= mode_wdata;
  end

  assign hs = (mode_q == MODE_HANDSHAKE);

  fc_cts_sync #(.STAGES(SYNC_STAGES)) u_cts (
    .clk(clk), .rst(rst), .cts_in(cts_in), .clr(rst_stat_stb),
    .irq_en(cts_irq_en), .cts_s(cts_s), .chg(cts_chg), .irq(cts_irq)
  );

  fc_rx_ctrl u_rx (
    .clk(clk), .rst(rst), .hs(hs), .en_stb(rx_en_stb), .dis_stb(rx_dis_stb),
    .full_stb(buf_full_stb), .full_clr(buf_full_clr), .rts(rts)
  );

  fc_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
    .clk(clk), .rst(rst), .tick(tick16), .hs(hs), .cts_s(cts_s),
    .wr(tx_wr), .wdata(tx_wdata), .txd(txd), .pending(tx_pending)
  );

  fc_break_det #(.OVS(OVS), .FRAME_BITS(FRAME_BITS), .END_SAMPLES(END_SAMPLES)) u_brk (
    .clk(clk), .rst(rst), .tick(tick16), .rxd(rxd), .clr(rst_stat_stb),
    .brk_stat(brk_stat)
  );

  a_r11_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (!rts && txd && !tx_pending && !cts_chg && !brk_stat));
endmodule

// File: tb/uart_flow_ctl_bench.sv
`timescale 1ns/1ps
module uart_flow_ctl_bench;
  logic clk = 0, rst = 1;
  logic mode_wr = 0, rx_en_stb = 0, rx_dis_stb = 0, buf_full_stb = 0, buf_full_clr = 0;
  logic rst_stat_stb = 0, cts_irq_en = 0, cts_in = 0, rxd = 1, tick16 = 1, tx_wr = 0;
  logic [3:0] mode_wdata = 0;
  logic [7:0] tx_wdata = 0;
  logic rts, txd, tx_pending, cts_chg, cts_irq, brk_stat;
  int checks = 0, errors = 0, frames = 0;
  logic [7:0] expq[$];

  always #4 clk = ~clk;

  uart_flow_ctl u_uart_flow_ctl (
    .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .rx_en_stb(rx_en_stb), .rx_dis_stb(rx_dis_stb), .buf_full_stb(buf_full_stb),
    .buf_full_clr(buf_full_clr), .rst_stat_stb(rst_stat_stb), .cts_irq_en(cts_irq_en),
    .cts_in(cts_in), .rxd(rxd), .tick16(tick16), .tx_wr(tx_wr), .tx_wdata(tx_wdata),
    .rts(rts), .txd(txd), .tx_pending(tx_pending), .cts_chg(cts_chg),
    .cts_irq(cts_irq), .brk_stat(brk_stat)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1; @(negedge clk); s = 0;
  endtask

  task automatic set_mode(input logic [3:0] m);
    @(negedge clk); mode_wdata = m; mode_wr = 1; @(negedge clk); mode_wr = 0;
  endtask

  // driver: push the expected character, then write it
  task automatic send(input logic [7:0] b);
    expq.push_back(b);
    @(negedge clk); tx_wdata = b; tx_wr = 1; @(negedge clk); tx_wr = 0;
  endtask

  // monitor: decode frames on txd (R7) and compare with the queue
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && txd === 1'b0) begin
        logic [7:0] got;
        logic stopb;
        cyc(7);
        check(txd === 1'b0, "R7 start bit", txd, 0);
        for (int i = 0; i < 8; i++) begin
          cyc(16);
          got[i] = txd;
        end
        cyc(16);
        stopb = txd;
        check(stopb === 1'b1, "R7 stop bit", stopb, 1);
        if (expq.size() == 0) check(0, "R6/R7 unexpected frame", got, -1);
        else begin
          logic [7:0] e;
          e = expq.pop_front();
          check(got === e, "R7 frame data", got, e);
        end
        frames++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int f0;
    cyc(4); rst = 0; cyc(1);
    // R11
    check(rts === 0, "R11 rts", rts, 0);
    check(txd === 1, "R11 txd", txd, 1);
    check(tx_pending === 0, "R11 pending", tx_pending, 0);
    check(cts_chg === 0 && cts_irq === 0 && brk_stat === 0, "R11 status",
          {cts_chg, cts_irq, brk_stat}, 0);

    // R1: normal mode, receiver off -> rts low
    cyc(3);
    check(rts === 0, "R1 rts low normal", rts, 0);
    // R2
    set_mode(4'h2); cyc(3);
    check(rts === 1, "R2 rts high rx off", rts, 1);
    // R5: both strobes -> disabled
    @(negedge clk); rx_en_stb = 1; rx_dis_stb = 1; @(negedge clk); rx_en_stb = 0; rx_dis_stb = 0;
    cyc(3);
    check(rts === 1, "R5 disable priority", rts, 1);
    pulse(rx_en_stb); cyc(3);
    check(rts === 0, "R5 enable", rts, 0);
    // R3
    pulse(buf_full_stb); cyc(3);
    check(rts === 1, "R3 buffer full", rts, 1);
    // R4: set wins over clear
    @(negedge clk); buf_full_stb = 1; buf_full_clr = 1; @(negedge clk); buf_full_stb = 0; buf_full_clr = 0;
    cyc(3);
    check(rts === 1, "R4 set wins", rts, 1);
    pulse(buf_full_clr); cyc(3);
    check(rts === 0, "R4 clear lowers rts", rts, 0);

    // R7 basic send, CTS low
    send(8'hA5); cyc(200);
    check(frames == 1 && expq.size() == 0, "R7 sent with cts low", frames, 1);

    // R8: CTS change with irq enabled
    cts_irq_en = 1; cts_in = 1; cyc(6);
    check(cts_chg === 1, "R8 change flag", cts_chg, 1);
    check(cts_irq === 1, "R8 irq", cts_irq, 1);
    // R6: CTS high blocks the start
    f0 = frames;
    send(8'h3C); cyc(400);
    check(frames == f0, "R6 no start while cts high", frames, f0);
    check(tx_pending === 1, "R6 held", tx_pending, 1);
    pulse(rst_stat_stb); cyc(3);
    check(cts_chg === 0 && cts_irq === 0, "R8 cleared", {cts_chg, cts_irq}, 0);
    cts_in = 0; cyc(200);
    check(frames == f0 + 1 && tx_pending === 0, "R6 released", frames, f0 + 1);
    cts_irq_en = 0; cyc(3);
    check(cts_chg === 1 && cts_irq === 0, "R8 irq masked", {cts_chg, cts_irq}, 2);
    pulse(rst_stat_stb);

    // R7: CTS rises mid-character, second char held
    f0 = frames;
    send(8'h81);
    send(8'h5E);
    cyc(40);
    cts_in = 1; cyc(400);
    check(frames == f0 + 1, "R7 in-flight completes", frames, f0 + 1);
    check(tx_pending === 1, "R6 second char held", tx_pending, 1);
    cts_in = 0; cyc(200);
    check(frames == f0 + 2, "R6 second char after release", frames, f0 + 2);

    // R1: normal mode ignores CTS and keeps rts low
    set_mode(4'h0);
    cts_in = 1; pulse(rx_dis_stb); cyc(5);
    check(rts === 0, "R1 rts low in normal mode", rts, 0);
    f0 = frames;
    send(8'hC3); cyc(200);
    check(frames == f0 + 1, "R1 cts ignored", frames, f0 + 1);
    set_mode(4'h3); cyc(3);
    check(rts === 0, "R1 mode 3 not handshaking", rts, 0);
    cts_in = 0;
    cyc(5); pulse(rst_stat_stb); cyc(3);

    // R9: break
    rxd = 0; cyc(120);
    check(brk_stat === 0, "R9 no break early", brk_stat, 0);
    cyc(60);
    check(brk_stat === 1, "R9 break detected", brk_stat, 1);
    pulse(rst_stat_stb); cyc(2);
    // R10: one-tick glitch does not end the break
    @(negedge clk); rxd = 1; @(negedge clk); rxd = 0; cyc(10);
    check(brk_stat === 0, "R10 single high ignored", brk_stat, 0);
    rxd = 1; cyc(10);
    check(brk_stat === 1, "R10 end of break", brk_stat, 1);

    cyc(10);
    check(expq.size() == 0, "R7 queue drained", expq.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule